// File: doc/BRIEF.md
# Ping-Pong Row/Column Symbol Interleaver

This block reorders a serial stream of one-bit symbols to spread channel burst errors apart. It holds two storage banks, each arranged as 24 rows of 16 columns (384 symbols). Incoming symbols are written into one bank row after row. At the same time the other bank, which holds the previous frame, is read out column after column. When the filling bank has taken its 384th symbol, the two banks exchange roles. The stream therefore runs without gaps and with a latency of one frame.

Output is paced by input. Every accepted input symbol produces exactly one output symbol on the next clock, taken from the draining bank. The output stays invalid until one complete frame has been stored. A frame-start flag on the input marks the first symbol of a frame. If that flag arrives in the middle of a frame, the block realigns to it and blanks its output until a new full frame has been collected.

Top module: `sym_interleaver`

## Requirements
- R1: While reset is held, and on the first clock after it is released, out_valid, out_sof and out_bit are all 0.
- R2: No valid output appears until 384 symbols have been accepted since reset or since the last realignment.
- R3: A symbol accepted at frame position k is stored at row k/16, column k%16. Output number n (counting from 0) of a drained frame is the symbol that was accepted at position (n mod 24)*16 + n/24 of the previous frame. The drain order is column 0 to 15, and inside each column row 0 to 23.
- R4: Every input symbol with in_valid high produces one output cycle on the following clock. A cycle with in_valid low produces out_valid low on the following clock.
- R5: out_sof is high exactly on output number 0 of each drained frame, and only while out_valid is high.
- R6: The banks swap roles after every 384 accepted symbols. Back-to-back frames stream out continuously, and frame j on the output equals frame j-1 on the input.
- R7: An in_sof flag on an accepted symbol whose frame position would not be 0 stores that symbol at position 0 and starts a new frame. Its output and all outputs up to the next full frame are invalid.
- R8: Idle cycles (in_valid low) between symbols change neither the frame position nor the bank roles, so the ordering of R3 holds across gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol present this cycle |
| in_sof | input | 1 | Input symbol is the first of a frame |
| in_bit | input | 1 | Input symbol value |
| out_valid | output | 1 | Output symbol present |
| out_sof | output | 1 | Output symbol is the first of a drained frame |
| out_bit | output | 1 | Output symbol value |

## Verification
The assertions assume that the inputs are known and settled at every rising edge after reset. They also assume that in_sof has meaning only when it is qualified by in_valid. The bench meets both conditions by driving all inputs only on falling edges. It holds the inputs at defined levels during reset and idle cycles, and it raises in_sof only together with in_valid. The stimulus covers contiguous frames, frames with random idle gaps, a frame containing a single set symbol, and a realignment in the middle of a frame. A behavioural model built from plain arrays predicts every output cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_t;

  // Fill position of the cell read out as the n-th symbol when a
  // rows x cols matrix is drained column by column.
  function automatic int unsigned drain_index(int unsigned n,
                                              int unsigned rows,
                                              int unsigned cols);
    return (n % rows) * cols + (n / rows);
  endfunction

  function automatic bank_t other_bank(bank_t b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DEPTH = 384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_bit;
  end

  assign rd_bit = cells[rd_addr];

  // R3: addresses stay inside the matrix
  p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH));
  p_rd_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(rd_addr) < DEPTH));

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int DEPTH = 384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_en,
  input  logic          sym_sof,
  output logic [AW-1:0] slot,
  output bank_t         fill_bank,
  output logic          primed,
  output logic          wrap_ev,
  output logic          resync_ev
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  assign slot      = sym_sof ? '0 : cnt_q;
  assign resync_ev = sym_en && sym_sof && (cnt_q != '0);
  assign wrap_ev   = sym_en && (slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      fill_bank <= BANK_A;
      primed    <= 1'b0;
    end else if (sym_en) begin
      cnt_q <= wrap_ev ? '0 : slot + 1'b1;
      if (wrap_ev) begin
        fill_bank <= other_bank(fill_bank);
        primed    <= 1'b1;
      end else if (resync_ev) begin
        primed <= 1'b0;
      end
    end
  end

  // R6: position counter never leaves the frame
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < DEPTH);
  // R6: a completed frame swaps the bank roles
  p_swap_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (fill_bank != $past(fill_bank)));
  // R8: idle cycles leave position and roles alone
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> ($stable(cnt_q) && $stable(fill_bank)));
  // R7: realignment drops the primed state
  p_resync_unprime_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ev |=> !primed);

endmodule

// File: rtl/sym_interleaver.sv
module sym_interleaver
  import ilv_pkg::*;
#(
  parameter int ROWS = 24,
  parameter int COLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_bit,
  output logic out_valid,
  output logic out_sof,
  output logic out_bit
);

  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int NBANK = 2;

  logic [AW-1:0]    slot;
  logic [AW-1:0]    rd_addr;
  bank_t            fill_bank;
  logic             primed;
  logic             wrap_ev;
  logic             resync_ev;
  logic             emit_ev;
  logic             fill_b;
  logic             rd_bit;
  logic [NBANK-1:0] bank_wr;
  logic [NBANK-1:0] bank_rd;

  ilv_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_en    (in_valid),
    .sym_sof   (in_sof),
    .slot      (slot),
    .fill_bank (fill_bank),
    .primed    (primed),
    .wrap_ev   (wrap_ev),
    .resync_ev (resync_ev)
  );

  assign fill_b  = (fill_bank == BANK_B);
  assign rd_addr = AW'(drain_index(int'(slot), ROWS, COLS));

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_wr[g] = in_valid && (fill_b == 1'(g));
    ilv_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr[g]),
      .wr_addr (slot),
      .wr_bit  (in_bit),
      .rd_addr (rd_addr),
      .rd_bit  (bank_rd[g])
    );
  end

  assign rd_bit  = fill_b ? bank_rd[0] : bank_rd[1];
  assign emit_ev = in_valid && primed && !resync_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= emit_ev;
      out_sof   <= emit_ev && (slot == '0);
      out_bit   <= emit_ev && rd_bit;
    end
  end

  // R5: frame start only on a valid symbol
  p_sof_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R4: no input symbol, no output symbol
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: nothing leaves before a whole frame is stored
  p_unprimed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !out_valid);
  // R7: a realigning symbol is never emitted
  p_resync_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ev |=> !out_valid);
  // R6: exactly one bank is written per accepted symbol
  p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(bank_wr) && (bank_wr != '0));

endmodule

// File: tb/sim_sym_interleaver.sv
`timescale 1ns/1ps
module sim_sym_interleaver;

  localparam int ROWS = 24;
  localparam int COLS = 16;
  localparam int N    = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_bit = 1'b0;
  logic out_valid, out_sof, out_bit;

  always #2.5 clk = ~clk;

  sym_interleaver #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_bit(in_bit), .out_valid(out_valid), .out_sof(out_sof),
    .out_bit(out_bit)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference
  bit held[N];
  bit fresh[N];
  int wpos   = 0;
  bit ready  = 0;
  bit exp_v  = 0, exp_s = 0, exp_b = 0;
  string tag = "R4";

  // single-one tracking for the direct ordering check
  bit   track   = 0;
  int   opos    = 0;
  int   hit_pos = -1;

  task automatic check1(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // compare previous expectation, then apply a new symbol (or idle)
  task automatic step(bit v, bit s, bit b);
    int idx;
    @(negedge clk);
    check1(tag, "out_valid", int'(out_valid), int'(exp_v));
    if (exp_v) begin
      check1(tag, "out_bit", int'(out_bit), int'(exp_b));
      check1("R5", "out_sof", int'(out_sof), int'(exp_s));
    end
    if (track && out_valid) begin
      if (out_sof) opos = 0;
      if (out_bit) hit_pos = opos;
      opos++;
    end
    in_valid = v; in_sof = s; in_bit = b;
    exp_v = 0; exp_s = 0; exp_b = 0;
    if (v) begin
      if (s && wpos != 0) begin
        ready = 0;            // R7 realignment
        idx = 0;
      end else begin
        idx = s ? 0 : wpos;
        exp_v = ready;
        exp_s = ready && (idx == 0);
        exp_b = ready && held[(idx % ROWS) * COLS + idx / ROWS];
      end
      fresh[idx] = b;
      wpos = idx + 1;
      if (wpos == N) begin
        held  = fresh;
        wpos  = 0;
        ready = 1;
      end
    end
  endtask

  initial begin
    int p;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1", "out_valid", int'(out_valid), 0);
    check1("R1", "out_sof", int'(out_sof), 0);
    check1("R1", "out_bit", int'(out_bit), 0);
    @(negedge clk);
    rst_n = 1;
    tag = "R1";
    step(0, 0, 0);
    // R2: first frame produces nothing valid
    tag = "R2";
    for (int i = 0; i < N; i++) step(1, i == 0, 1'($urandom));
    // R3 / R6: back-to-back random frames
    tag = "R3";
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < N; i++) step(1, i == 0, 1'($urandom));
    // R8: gaps inside frames
    tag = "R8";
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 3) == 0) step(0, 0, 0);
        step(1, i == 0, 1'($urandom));
      end
    // R3: single set symbol at fill position p, drained position computed directly
    tag = "R3";
    p = 17;
    for (int i = 0; i < N; i++) step(1, i == 0, i == p);
    track = 1; opos = 0; hit_pos = -1;
    tag = "R6";
    for (int i = 0; i < N; i++) step(1, i == 0, 1'b0);
    track = 0;
    check1("R3", "single-one output position", hit_pos, p / COLS + (p % COLS) * ROWS);
    // R7: realign mid-frame, then two frames
    tag = "R7";
    for (int i = 0; i < 100; i++) step(1, i == 0, 1'($urandom));
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < N; i++) step(1, i == 0, 1'($urandom));
    // R4: trailing idle
    tag = "R4";
    repeat (4) step(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule